// File: doc/BRIEF.md
# Dual Reference Selection Controller

This block picks which of two clock references, a primary and a secondary, a digital PLL should track. Each cycle it looks at one validity flag per reference, a two-bit failure-handling mode and a bit that names the preferred reference. From these it drives the selected reference, a holdover request and a one-cycle switch event. Downstream phase-continuity logic uses the switch event to realign its phase offset. A separate realign request input is turned into a single-cycle pulse for the same logic.

In automatic mode the controller tracks the preferred reference while it is valid. When the tracked reference fails, the controller first requests holdover. It falls back to the other reference only after a programmable minimum number of holdover cycles, which filters out brief glitches. It returns to the preferred reference as soon as that reference is valid again. In the two forced modes only the named reference is ever tracked, and losing it means holdover until it returns. The two references may run at different nominal frequencies, and a switch between them needs no reset.

Top module: `ref_select_ctrl`

## Requirements
- R1: While `rst` is high and after its release, the state is holdover asserted, `sel_ref` = 0 (primary), and `switch_pulse` and `realign_pulse` low. The internal mode register resets to automatic, so the first decision after reset is made in automatic mode whatever `mode` is driven.
- R2: `mode` encoding: 2'b00 automatic, 2'b01 forced primary, 2'b10 forced secondary, 2'b11 automatic. `prefer_sec` = 0 prefers the primary and 1 the secondary. `sel_ref` = 0 means primary and 1 means secondary. `mode` and `prefer_sec` are registered, so a change first affects the decision at the second rising edge after it is applied.
- R3: In automatic mode, while tracking the non-preferred reference with the preferred one valid, `sel_ref` moves to the preferred reference at the next edge without asserting holdover.
- R4: When the tracked reference becomes invalid, holdover is asserted at the next edge and `sel_ref` keeps its value.
- R5: A change of `sel_ref` on leaving holdover happens only after holdover has been high for HOLD_MIN cycles. If the reference held in `sel_ref` becomes usable again before then, holdover ends at the next edge with `sel_ref` unchanged.
- R6: When both references are invalid, holdover is high from the next edge and stays high until at least one reference is valid.
- R7: In a forced mode, holdover is low only while the named reference is selected. A tracked reference the mode disallows is dropped to holdover at once. Loss of the named reference means holdover until it recovers, and `prefer_sec` has no effect.
- R8: `switch_pulse` is high for exactly the one cycle in which `sel_ref` has just changed or holdover has just fallen, and low in every other cycle.
- R9: A rising edge on `realign_req` yields `realign_pulse` high for exactly one cycle, after the first edge that samples the request high.
- R10: In automatic mode, after a fallback to the secondary, setting `prefer_sec` to 1 keeps the secondary selected when the primary recovers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_ok | input | 1 | Primary reference valid |
| sec_ok | input | 1 | Secondary reference valid |
| mode | input | 2 | Failure-handling mode (see R2) |
| prefer_sec | input | 1 | 1 prefers the secondary reference |
| realign_req | input | 1 | Realign request level |
| sel_ref | output | 1 | Selected reference, 0 primary, 1 secondary |
| holdover | output | 1 | Holdover request to the PLL |
| switch_pulse | output | 1 | One-cycle selection change event |
| realign_pulse | output | 1 | One-cycle realign event |

## Verification
A wrong tracking state shows at the ports within one edge of the validity or configuration change that exposes it. It appears as holdover not rising on a loss, as `sel_ref` not returning to the preferred reference, or as a switch event in a cycle with no change. A hold counter that is wrong shows as a fallback one or more cycles early or late against the exact HOLD_MIN count. A mode register that is stale or reset wrongly shows in the first two edges after reset or after a mode write, where the forced modes must drop a disallowed reference.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    typedef enum logic [1:0] {
        MODE_AUTO  = 2'b00,
        MODE_FPRI  = 2'b01,
        MODE_FSEC  = 2'b10,
        MODE_AUTO2 = 2'b11
    } fd_mode_t;

    typedef enum logic {
        REF_PRI = 1'b0,
        REF_SEC = 1'b1
    } ref_id_t;

    typedef struct packed {
        logic    found;
        ref_id_t which;
    } pick_t;

    function automatic logic is_forced(input fd_mode_t m);
        return (m == MODE_FPRI) || (m == MODE_FSEC);
    endfunction

    function automatic ref_id_t forced_ref(input fd_mode_t m);
        return (m == MODE_FSEC) ? REF_SEC : REF_PRI;
    endfunction

    function automatic logic ref_valid(input ref_id_t r, input logic p_ok, input logic s_ok);
        return (r == REF_SEC) ? s_ok : p_ok;
    endfunction

    function automatic logic ref_allowed(input fd_mode_t m, input ref_id_t r);
        return !is_forced(m) || (forced_ref(m) == r);
    endfunction

    function automatic ref_id_t other_ref(input ref_id_t r);
        return (r == REF_SEC) ? REF_PRI : REF_SEC;
    endfunction

    // Reference the controller would like to track right now.
    function automatic pick_t pick_ref(input fd_mode_t m, input ref_id_t pref,
                                       input logic p_ok, input logic s_ok);
        pick_t res;
        res.found = 1'b0;
        res.which = REF_PRI;
        if (is_forced(m)) begin
            res.which = forced_ref(m);
            res.found = ref_valid(res.which, p_ok, s_ok);
        end else if (ref_valid(pref, p_ok, s_ok)) begin
            res.which = pref;
            res.found = 1'b1;
        end else if (ref_valid(other_ref(pref), p_ok, s_ok)) begin
            res.which = other_ref(pref);
            res.found = 1'b1;
        end
        return res;
    endfunction

endpackage

// File: rtl/refsel_cfg.sv
module refsel_cfg
    import refsel_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode_in,
    input  logic         pref_in,
    output fd_mode_t     mode_q,
    output ref_id_t      pref_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_AUTO;
            pref_q <= REF_PRI;
        end else begin
            mode_q <= fd_mode_t'(mode_in);
            pref_q <= ref_id_t'(pref_in);
        end
    end
endmodule

// File: rtl/refsel_hold_timer.sv
module refsel_hold_timer #(
    parameter int unsigned HOLD_MIN = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic in_hold,
    output logic expired
);
    localparam int unsigned CW = $clog2(HOLD_MIN + 1) + 1;
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_MIN - 1);

    logic [CW-1:0] cnt;

    assign expired = (cnt >= LIMIT);

    always_ff @(posedge clk) begin
        if (rst || !in_hold) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
    import refsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pri_ok,
    input  logic     sec_ok,
    input  fd_mode_t mode_q,
    input  ref_id_t  pref_q,
    input  logic     expired,
    output ref_id_t  sel_q,
    output logic     hold_q,
    output logic     pulse_q
);
    pick_t   want;
    logic    cur_ok;
    logic    cur_allowed;
    ref_id_t sel_d;
    logic    hold_d;

    always_comb begin
        want        = pick_ref(mode_q, pref_q, pri_ok, sec_ok);
        cur_ok      = ref_valid(sel_q, pri_ok, sec_ok);
        cur_allowed = ref_allowed(mode_q, sel_q);
        sel_d       = sel_q;
        hold_d      = hold_q;
        if (!hold_q) begin
            if (!cur_ok || !cur_allowed) begin
                hold_d = 1'b1;
            end else if (want.found && want.which != sel_q) begin
                sel_d = want.which;
            end
        end else if (want.found) begin
            if (want.which == sel_q) begin
                hold_d = 1'b0;
            end else if (expired) begin
                hold_d = 1'b0;
                sel_d  = want.which;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= REF_PRI;
            hold_q  <= 1'b1;
            pulse_q <= 1'b0;
        end else begin
            sel_q   <= sel_d;
            hold_q  <= hold_d;
            pulse_q <= (sel_d != sel_q) || (hold_q && !hold_d);
        end
    end

    // R6: both references invalid forces holdover at the next edge
    a_r6_both_lost_hold: assert property (@(posedge clk) disable iff (rst)
        (!pri_ok && !sec_ok) |=> hold_q);

    // R7: forced primary never tracks the secondary
    a_r7_forced_pri_only: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FPRI) |=> (hold_q || sel_q == REF_PRI));

    // R7: forced secondary never tracks the primary
    a_r7_forced_sec_only: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FSEC) |=> (hold_q || sel_q == REF_SEC));

    // R4: loss of the tracked reference enters holdover without a switch
    a_r4_loss_to_hold: assert property (@(posedge clk) disable iff (rst)
        (!hold_q && !ref_valid(sel_q, pri_ok, sec_ok)) |=> (hold_q && $stable(sel_q)));

    // R5: a switch out of holdover only after the minimum hold time
    a_r5_min_hold: assert property (@(posedge clk) disable iff (rst)
        ($fell(hold_q) && sel_q != $past(sel_q)) |-> $past(expired));

    // R8: switch event marks exactly a selection change or holdover exit
    a_r8_pulse_match: assert property (@(posedge clk) disable iff (rst)
        pulse_q == ((sel_q != $past(sel_q)) || $fell(hold_q)));

    // R3: automatic mode returns to a valid preferred reference
    a_r3_revert: assert property (@(posedge clk) disable iff (rst)
        (!is_forced(mode_q) && !hold_q && sel_q != pref_q
         && ref_valid(sel_q, pri_ok, sec_ok) && ref_valid(pref_q, pri_ok, sec_ok))
        |=> (sel_q == $past(pref_q) && !hold_q));
endmodule

// File: rtl/refsel_edge.sv
module refsel_edge (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic pulse
);
    logic req_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d <= 1'b0;
            pulse <= 1'b0;
        end else begin
            req_d <= req;
            pulse <= req && !req_d;
        end
    end

    // R9: the realign event never lasts two cycles
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
endmodule

// File: rtl/ref_select_ctrl.sv
module ref_select_ctrl
    import refsel_pkg::*;
#(
    parameter int unsigned HOLD_MIN = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pri_ok,
    input  logic       sec_ok,
    input  logic [1:0] mode,
    input  logic       prefer_sec,
    input  logic       realign_req,
    output logic       sel_ref,
    output logic       holdover,
    output logic       switch_pulse,
    output logic       realign_pulse
);
    fd_mode_t mode_q;
    ref_id_t  pref_q;
    ref_id_t  sel_q;
    logic     hold_q;
    logic     expired;

    refsel_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .mode_in (mode),
        .pref_in (prefer_sec),
        .mode_q  (mode_q),
        .pref_q  (pref_q)
    );

    refsel_hold_timer #(.HOLD_MIN(HOLD_MIN)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .in_hold (hold_q),
        .expired (expired)
    );

    refsel_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pri_ok  (pri_ok),
        .sec_ok  (sec_ok),
        .mode_q  (mode_q),
        .pref_q  (pref_q),
        .expired (expired),
        .sel_q   (sel_q),
        .hold_q  (hold_q),
        .pulse_q (switch_pulse)
    );

    refsel_edge u_realign (
        .clk   (clk),
        .rst   (rst),
        .req   (realign_req),
        .pulse (realign_pulse)
    );

    assign sel_ref  = sel_q;
    assign holdover = hold_q;

    // R1: reset leaves holdover requested on the primary
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (holdover && !sel_ref && !switch_pulse && !realign_pulse));
endmodule

// File: tb/tb_ref_select_ctrl.sv
module tb_ref_select_ctrl;
    localparam int HM = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pri_ok = 1'b1;
    logic       sec_ok = 1'b1;
    logic [1:0] mode = 2'b10;
    logic       prefer_sec = 1'b0;
    logic       realign_req = 1'b0;
    logic       sel_ref, holdover, switch_pulse, realign_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    ref_select_ctrl #(.HOLD_MIN(HM)) dut (
        .clk           (clk),
        .rst           (rst),
        .pri_ok        (pri_ok),
        .sec_ok        (sec_ok),
        .mode          (mode),
        .prefer_sec    (prefer_sec),
        .realign_req   (realign_req),
        .sel_ref       (sel_ref),
        .holdover      (holdover),
        .switch_pulse  (switch_pulse),
        .realign_pulse (realign_pulse)
    );

    always #4 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic chk3(input string tag, input logic s, input logic h, input logic p);
        chk({tag, " sel_ref"}, sel_ref, s);
        chk({tag, " holdover"}, holdover, h);
        chk({tag, " switch_pulse"}, switch_pulse, p);
    endtask

    task automatic t_reset;
        tick(3);
        chk3("R1 in reset", 1'b0, 1'b1, 1'b0);
        chk("R1 in reset realign_pulse", realign_pulse, 1'b0);
        rst = 1'b0;
        tick(1);
        chk3("R1 first decision automatic", 1'b0, 1'b0, 1'b1);
        mode = 2'b00;
        tick(1);
        chk3("R7 forced secondary drops primary", 1'b0, 1'b1, 1'b0);
        tick(1);
        chk3("R2 back to automatic", 1'b0, 1'b0, 1'b1);
        tick(1);
        chk("R8 pulse one cycle", switch_pulse, 1'b0);
    endtask

    task automatic t_fallback;
        pri_ok = 1'b0;
        tick(1);
        chk3("R4 loss enters holdover", 1'b0, 1'b1, 1'b0);
        tick(HM - 1);
        chk3("R5 still holding at HM", 1'b0, 1'b1, 1'b0);
        tick(1);
        chk3("R5 fallback after HM", 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_revert;
        pri_ok = 1'b1;
        tick(1);
        chk3("R3 revert to preferred", 1'b0, 1'b0, 1'b1);
        tick(1);
        chk("R8 quiet after revert", switch_pulse, 1'b0);
    endtask

    task automatic t_glitch;
        pri_ok = 1'b0;
        tick(2);
        chk3("R4 glitch holdover", 1'b0, 1'b1, 1'b0);
        pri_ok = 1'b1;
        tick(1);
        chk3("R5 early recovery same ref", 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_pref_lock;
        pri_ok = 1'b0;
        tick(HM + 1);
        chk3("R10 fallback done", 1'b1, 1'b0, 1'b1);
        prefer_sec = 1'b1;
        tick(2);
        pri_ok = 1'b1;
        tick(3);
        chk3("R10 no revert after pref change", 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_both_lost;
        pri_ok = 1'b0;
        sec_ok = 1'b0;
        tick(1);
        chk3("R6 both lost holdover", 1'b1, 1'b1, 1'b0);
        tick(10);
        chk3("R6 stays in holdover", 1'b1, 1'b1, 1'b0);
        pri_ok = 1'b1;
        tick(1);
        chk3("R6 exit onto valid backup", 1'b0, 1'b0, 1'b1);
        sec_ok = 1'b1;
        tick(1);
        chk3("R3 revert to preferred secondary", 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_forced_pri;
        mode = 2'b01;
        tick(1);
        chk3("R2 mode takes effect next cycle", 1'b1, 1'b0, 1'b0);
        tick(1);
        chk3("R7 disallowed secondary dropped", 1'b1, 1'b1, 1'b0);
        tick(HM - 1);
        chk3("R5 forced hold minimum", 1'b1, 1'b1, 1'b0);
        tick(1);
        chk3("R7 forced primary selected", 1'b0, 1'b0, 1'b1);
        pri_ok = 1'b0;
        tick(8);
        chk3("R7 no switch to secondary", 1'b0, 1'b1, 1'b0);
        prefer_sec = 1'b0;
        tick(2);
        prefer_sec = 1'b1;
        tick(2);
        chk3("R7 preference ignored", 1'b0, 1'b1, 1'b0);
        pri_ok = 1'b1;
        tick(1);
        chk3("R7 named reference recovers", 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_forced_sec;
        prefer_sec = 1'b0;
        mode = 2'b10;
        tick(2);
        chk3("R7 forced secondary drops primary", 1'b0, 1'b1, 1'b0);
        tick(HM - 1);
        chk("R5 forced secondary holding", holdover, 1'b1);
        tick(1);
        chk3("R7 forced secondary selected", 1'b1, 1'b0, 1'b1);
        prefer_sec = 1'b1;
        mode = 2'b11;
        tick(3);
        chk3("R2 code 11 keeps secondary", 1'b1, 1'b0, 1'b0);
        prefer_sec = 1'b0;
        tick(2);
        chk3("R2 code 11 acts automatic", 1'b0, 1'b0, 1'b1);
        mode = 2'b00;
        tick(2);
    endtask

    task automatic t_realign;
        realign_req = 1'b1;
        tick(1);
        chk("R9 realign pulse", realign_pulse, 1'b1);
        tick(1);
        chk("R9 realign one cycle", realign_pulse, 1'b0);
        tick(1);
        chk("R9 held request no repeat", realign_pulse, 1'b0);
        realign_req = 1'b0;
        tick(1);
        chk("R9 idle low", realign_pulse, 1'b0);
        realign_req = 1'b1;
        tick(1);
        chk("R9 second request", realign_pulse, 1'b1);
        realign_req = 1'b0;
        tick(1);
        chk3("R8 no switch on realign", 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset;
        t_fallback;
        t_revert;
        t_glitch;
        t_pref_lock;
        t_both_lost;
        t_forced_pri;
        t_forced_sec;
        t_realign;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule